// File: doc/BRIEF.md
# Compare and Condition Evaluator

This block subtracts a second 16-bit operand from a first one and discards the difference. It keeps only the six arithmetic flags: carry (borrow), parity, auxiliary carry, zero, sign and overflow. In the same cycle, a 4-bit condition selector is tested against those fresh flags. The result is one taken/not-taken bit, which a conditional branch or a set-on-condition operation can use directly.

Operands, selector and a valid strobe are sampled on a rising clock edge. The flags, the condition bit and an output valid are registered and appear one cycle later. They keep their values while no new request arrives. The sixteen selector codes are grouped in pairs. Each even code names a test, and the odd code after it asks for the opposite answer.

Top module: `cmp_cc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid_o`, `flags_o` and `taken_o` become 0.
- R2: `out_valid_o` is high exactly in the cycle after a cycle with `in_valid` high. `flags_o` and `taken_o` then describe `opa_i - opb_i` and `cc_i` as sampled at that edge.
- R3: `flags_o[3]` (zero) is 1 only when the operands are equal. `flags_o[0]` (carry) is 1 when `opa_i < opb_i` as unsigned numbers, meaning the subtraction borrows.
- R4: `flags_o[4]` (sign) is bit 15 of the difference. `flags_o[5]` (overflow) is 1 when the two's-complement difference does not fit in 16 bits.
- R5: `flags_o[2]` (auxiliary) is the borrow out of bit 3. `flags_o[1]` (parity) is 1 when bits 7:0 of the difference hold an even number of ones.
- R6: The single-flag tests are: code 0 is overflow set, code 2 is carry set, code 4 is zero set, code 8 is sign set and code 10 is parity set.
- R7: Code 6 (below-or-equal) is true when carry OR zero is 1. Code 7 (above) is its complement.
- R8: Code 12 (less) is true when sign XOR overflow is 1. Code 14 (less-or-equal) is true when (sign XOR overflow) OR zero is 1. The signed results therefore follow a signed comparison of the operands.
- R9: Every odd code N yields the inverse of code N-1 for the same flags.
- R10: A cycle with `in_valid` low leaves `flags_o` and `taken_o` unchanged and drops `out_valid_o`.
- R11: Comparing 0x1234 with 0xABCD gives zero 0, sign 0, carry 1, auxiliary 1, overflow 0 and parity 0, so `flags_o` = 6'h05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| opa_i | input | 16 | Minuend operand |
| opb_i | input | 16 | Subtrahend operand |
| cc_i | input | 4 | Condition selector |
| out_valid_o | output | 1 | Result valid, one cycle after request |
| flags_o | output | 6 | {overflow, sign, zero, aux, parity, carry} |
| taken_o | output | 1 | Condition result |

## Verification
The block has only one register stage, so any fault in the subtractor or the condition decoder shows on `flags_o` or `taken_o` in the very next cycle. A polarity fault in the pairing makes every odd code disagree with the model at once. A wrong borrow or overflow term shows only for operand pairs that cross the unsigned or signed boundary, such as 0x8000 against 0x0001 or 0x7FFF against 0xFFFF, so those pairs are swept across all sixteen codes. A hold fault shows in the first idle cycle, where the operands change while the strobe is low.

// File: rtl/cmp_cc_pkg.sv
package cmp_cc_pkg;

  // Flag word layout, msb first: overflow, sign, zero, aux, parity, carry
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } cmp_flags_t;

  localparam int FLAG_W = $bits(cmp_flags_t);
  localparam int CC_W   = 4;

  // Even codes are base tests; the following odd code inverts them
  typedef enum logic [CC_W-1:0] {
    CC_OVF    = 4'd0,  CC_NOVF  = 4'd1,
    CC_BELOW  = 4'd2,  CC_NBELOW = 4'd3,
    CC_EQ     = 4'd4,  CC_NE    = 4'd5,
    CC_BE     = 4'd6,  CC_ABOVE = 4'd7,
    CC_SIGN   = 4'd8,  CC_NSIGN = 4'd9,
    CC_PEVEN  = 4'd10, CC_PODD  = 4'd11,
    CC_LT     = 4'd12, CC_GE    = 4'd13,
    CC_LE     = 4'd14, CC_GT    = 4'd15
  } cc_code_t;

endpackage

// File: rtl/cmp_subtractor.sv
module cmp_subtractor
  import cmp_cc_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int PAR_BITS = 8,
  parameter int AUX_BITS = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output cmp_flags_t       flags_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]    wide_diff;
  logic [AUX_BITS:0] nib_diff;
  logic [WIDTH-1:0]  diff;

  assign wide_diff = {1'b0, a_i} - {1'b0, b_i};
  assign nib_diff  = {1'b0, a_i[AUX_BITS-1:0]} - {1'b0, b_i[AUX_BITS-1:0]};
  assign diff      = wide_diff[WIDTH-1:0];

  always_comb begin
    flags_o.cf = wide_diff[WIDTH];
    flags_o.zf = (diff == '0);
    flags_o.sf = diff[MSB];
    flags_o.of = (a_i[MSB] ^ b_i[MSB]) & (a_i[MSB] ^ diff[MSB]);
    flags_o.af = nib_diff[AUX_BITS];
    flags_o.pf = ~^diff[PAR_BITS-1:0];
  end

endmodule

// File: rtl/cmp_cond_eval.sv
module cmp_cond_eval
  import cmp_cc_pkg::*;
(
  input  cmp_flags_t       flags_i,
  input  logic [CC_W-1:0]  cc_i,
  output logic             taken_o
);
  logic base;
  logic lt;

  assign lt = flags_i.sf ^ flags_i.of;

  always_comb begin
    case (cc_code_t'({cc_i[CC_W-1:1], 1'b0}))
      CC_OVF:   base = flags_i.of;
      CC_BELOW: base = flags_i.cf;
      CC_EQ:    base = flags_i.zf;
      CC_BE:    base = flags_i.cf | flags_i.zf;
      CC_SIGN:  base = flags_i.sf;
      CC_PEVEN: base = flags_i.pf;
      CC_LT:    base = lt;
      CC_LE:    base = lt | flags_i.zf;
      default:  base = 1'b0;
    endcase
  end

  // R9: low selector bit flips the sense of the base test
  assign taken_o = base ^ cc_i[0];

endmodule

// File: rtl/cmp_cc_unit.sv
module cmp_cc_unit
  import cmp_cc_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int PAR_BITS = 8,
  parameter int AUX_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WIDTH-1:0]  opa_i,
  input  logic [WIDTH-1:0]  opb_i,
  input  logic [3:0]        cc_i,
  output logic              out_valid_o,
  output logic [5:0]        flags_o,
  output logic              taken_o
);
  localparam int MSB = WIDTH - 1;

  cmp_flags_t flags_d;
  cmp_flags_t flags_q;
  logic       taken_d;
  logic       taken_q;
  logic       valid_q;

  cmp_subtractor #(
    .WIDTH   (WIDTH),
    .PAR_BITS(PAR_BITS),
    .AUX_BITS(AUX_BITS)
  ) u_sub (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .flags_o(flags_d)
  );

  cmp_cond_eval u_eval (
    .flags_i(flags_d),
    .cc_i   (cc_i),
    .taken_o(taken_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      flags_q <= '0;
      taken_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        flags_q <= flags_d;
        taken_q <= taken_d;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign flags_o     = flags_q;
  assign taken_o     = taken_q;

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid_o);
  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid_o);
  // R3
  zero_equal_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> (flags_q.zf == ($past(opa_i) == $past(opb_i))));
  // R3
  carry_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> (flags_q.cf == ($past(opa_i) < $past(opb_i))));
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && flags_q.of) |-> ($past(opa_i[MSB]) != $past(opb_i[MSB])));
  // R8
  signed_less_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && ($past(cc_i) == 4'd12)) |->
      (taken_q == ($signed($past(opa_i)) < $signed($past(opb_i)))));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(flags_q) && $stable(taken_q)));

endmodule

// File: tb/test_cmp_cc_unit.sv
module test_cmp_cc_unit;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [3:0]   cc;
  logic         out_valid;
  logic [5:0]   flags;
  logic         taken;

  always #4 clk = ~clk;

  cmp_cc_unit i_cmp_cc_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .opa_i(a), .opb_i(b), .cc_i(cc),
    .out_valid_o(out_valid), .flags_o(flags), .taken_o(taken)
  );

  typedef struct {
    logic [5:0]   fl;
    logic         tk;
    logic [3:0]   code;
    logic [W-1:0] ea;
    logic [W-1:0] eb;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  logic [31:0] seed = 32'h2545_f491;

  // flags {of, sf, zf, af, pf, cf} from the requirements
  function automatic logic [5:0] ref_flags(logic [W-1:0] x, logic [W-1:0] y);
    logic [W-1:0] d;
    logic cf, zf, sf, of, af, pf;
    d  = x - y;
    cf = (x < y);
    zf = (x == y);
    sf = d[W-1];
    of = (($signed(x) < $signed(y)) != sf);
    af = (x[3:0] < y[3:0]);
    pf = ~^d[7:0];
    return {of, sf, zf, af, pf, cf};
  endfunction

  function automatic logic ref_taken(logic [W-1:0] x, logic [W-1:0] y, logic [3:0] c);
    logic [5:0] f;
    logic r;
    f = ref_flags(x, y);
    case (c[3:1])
      3'd0: r = f[5];
      3'd1: r = f[0];
      3'd2: r = f[3];
      3'd3: r = f[0] | f[3];
      3'd4: r = f[4];
      3'd5: r = f[1];
      3'd6: r = ($signed(x) < $signed(y));
      default: r = ($signed(x) <= $signed(y));
    endcase
    return r ^ c[0];
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_pair(logic [W-1:0] x, logic [W-1:0] y);
    exp_t e;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      in_valid = 1'b1; a = x; b = y; cc = 4'(c);
      e.fl = ref_flags(x, y);
      e.tk = ref_taken(x, y, 4'(c));
      e.code = 4'(c); e.ea = x; e.eb = y;
      q.push_back(e);
    end
    @(negedge clk);
    in_valid = 1'b0;
    a = ~x ^ 16'h5a5a; b = y + 16'h0137; cc = ~cc;
    @(negedge clk);
    a = seed[15:0]; b = seed[31:16];
  endtask

  function automatic logic [31:0] next_rand(logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  // scoreboard monitor
  logic [5:0] last_fl;
  logic       last_tk;
  bit         seen = 0;
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst) continue;
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R2 unexpected valid", 32'd1, 32'd0);
        end else begin
          exp_t e;
          string tg;
          e = q.pop_front();
          check(flags[0] == e.fl[0] && flags[3] == e.fl[3], "R3 carry/zero", 32'(flags), 32'(e.fl));
          check(flags[4] == e.fl[4] && flags[5] == e.fl[5], "R4 sign/overflow", 32'(flags), 32'(e.fl));
          check(flags[2] == e.fl[2] && flags[1] == e.fl[1], "R5 aux/parity", 32'(flags), 32'(e.fl));
          if (e.code[3:1] == 3'd3)      tg = "R7 unsigned cond";
          else if (e.code >= 4'd12)     tg = "R8 signed cond";
          else                          tg = "R6 single-flag cond";
          if (e.code[0]) tg = {tg, " R9 inverted"};
          check(taken == e.tk, $sformatf("%s code=%0d a=%h b=%h", tg, e.code, e.ea, e.eb),
                32'(taken), 32'(e.tk));
          if (e.ea == 16'h1234 && e.eb == 16'habcd)
            check(flags == 6'h05, "R11 example compare", 32'(flags), 32'h05);
          last_fl = flags; last_tk = taken; seen = 1;
        end
      end else begin
        check(q.size() == 0, "R2 missing valid", 32'(q.size()), 32'd0);
        if (seen) begin
          check(flags == last_fl && taken == last_tk, "R10 hold",
                {25'd0, taken, flags}, {25'd0, last_tk, last_fl});
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; a = '0; b = '0; cc = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 valid in reset", 32'(out_valid), 32'd0);
    check(flags == 6'd0, "R1 flags in reset", 32'(flags), 32'd0);
    check(taken == 1'b0, "R1 taken in reset", 32'(taken), 32'd0);
    rst = 1'b0;
    send_pair(16'h1234, 16'habcd);
    send_pair(16'h8000, 16'h0001);
    send_pair(16'h5555, 16'h5555);
    send_pair(16'h0000, 16'h0000);
    send_pair(16'h0000, 16'h0001);
    send_pair(16'hffff, 16'h0000);
    send_pair(16'h7fff, 16'hffff);
    send_pair(16'h8000, 16'h8000);
    send_pair(16'h0001, 16'h8000);
    send_pair(16'h0010, 16'h0001);
    send_pair(16'h7fff, 16'h8000);
    for (int i = 0; i < 30; i++) begin
      seed = next_rand(seed);
      send_pair(seed[15:0], (i % 5 == 0) ? seed[15:0] : seed[31:16]);
    end
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2 drained", 32'(q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule